// File: doc/BRIEF.md
# Encoded-Ratio Clock Divider

This block divides a fast synthesizer clock by a ratio given as a 4-bit code rather than as a binary count. The two low code bits pick a base factor and the two high bits pick a left shift of zero to three places, so the ratio is the base times 1, 2, 4 or 8. A 2-bit family select picks which set of base factors applies: the processor-clock family, the link-clock family or the serial-reference family. A single divider instance serves any of these clock trees.

The divided output has a duty cycle of exactly half the period, measured in half-periods of the input clock, even when the ratio is odd. Odd ratios use a falling-edge stage that stretches the high phase by half an input cycle. A companion output toggles on every rising edge of the divided clock. It runs at half the divided rate, with its edges aligned to those of the divided clock, and in the link family it serves as the bus clock. A new code takes effect only when the running period ends, so a ratio change never produces a runt or a stretched pulse.

Top module: `enc_ratio_div`

## Requirements
- R1: With family select 00, code bits [1:0] = 00, 01, 10, 11 select the bases 2, 3, 5 and 15. Code bits [3:2] = k multiply the base by 2^k, so the divided period spans base × 2^k input cycles, from 2 up to 120.
- R2: With family select 01, the bases are 4, 3, 5 and 15 for code bits [1:0] = 00..11, with the same shift by code bits [3:2], giving ratios from 3 up to 120.
- R3: With family select 10, the bases are 2, 3, 5 and 7 for code bits [1:0] = 00..11, with the same shift, giving a maximum ratio of 56.
- R4: Family select 11 decodes exactly as family select 00.
- R5: For every ratio R, odd or even, the divided clock is high for exactly R input half-periods and low for R input half-periods.
- R6: The companion output changes level at each rising edge of the divided clock and at no other time. Its period is 2R input cycles and it is high for R input cycles.
- R7: A change of code or family select takes effect only at the end of the current divided period. The period in progress finishes with its old high and low widths.
- R8: While rst_n is low, both outputs are low. After release the divider runs at ratio 2 until the end of its first period, and it then loads the code presented at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| fam_sel | input | 2 | Family select: 00 processor, 01 link, 10 serial reference, 11 same as 00 |
| ratio_code | input | 4 | Bits [1:0] base select, bits [3:2] power-of-two shift |
| div_clk | output | 1 | Divided clock, 50% duty |
| half_clk | output | 1 | Companion clock at half the divided rate |

## Verification
The decode is tried with every base slot in each family and with shifts of 0 to 3. Codes with base slot 00 tell the processor family and the link family apart, and base slot 11 tells the serial family apart from the other two. Odd ratios (3, 7, 15) against even ones (2, 10, 120) show whether the half-cycle stretch is applied only where it belongs. Switching from the largest ratio to the smallest just after a rising edge shows whether the running period is completed before the new code is used.

// File: rtl/enc_div_pkg.sv
package enc_div_pkg;

  localparam int CODE_W  = 4;
  localparam int SHIFT_W = CODE_W - 2;
  localparam int RATIO_W = 7;

  typedef enum logic [1:0] {
    FAM_CORE  = 2'b00,
    FAM_LINK  = 2'b01,
    FAM_SER   = 2'b10,
    FAM_SPARE = 2'b11
  } family_e;

  // Base factor for the low two code bits within a family.
  function automatic logic [RATIO_W-1:0] base_of(input family_e fam, input logic [1:0] slot);
    logic [RATIO_W-1:0] b;
    case (slot)
      2'd0:    b = (fam == FAM_LINK) ? RATIO_W'(4) : RATIO_W'(2);
      2'd1:    b = RATIO_W'(3);
      2'd2:    b = RATIO_W'(5);
      default: b = (fam == FAM_SER) ? RATIO_W'(7) : RATIO_W'(15);
    endcase
    return b;
  endfunction

  // Full ratio: base shifted left by the high code bits.
  function automatic logic [RATIO_W-1:0] ratio_of(input family_e fam, input logic [CODE_W-1:0] code);
    logic [SHIFT_W-1:0] sh;
    sh = code[CODE_W-1:2];
    return base_of(fam, code[1:0]) << sh;
  endfunction

endpackage

// File: rtl/enc_div_ctl.sv
module enc_div_ctl
  import enc_div_pkg::*;
#(
  parameter int RATIO_W   = enc_div_pkg::RATIO_W,
  parameter int CODE_W    = enc_div_pkg::CODE_W,
  parameter int RST_RATIO = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  family_e            fam,
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] ratio_q,
  output logic [RATIO_W-1:0] cnt_q,
  output logic [RATIO_W-1:0] ratio_nxt,
  output logic [RATIO_W-1:0] cnt_nxt,
  output logic               term
);

  logic [RATIO_W-1:0] ratio_dec;

  assign ratio_dec = ratio_of(fam, code);
  assign term      = (cnt_q == ratio_q - RATIO_W'(1));

  // The decoded ratio is only admitted at the last count of a period.
  always_comb begin
    ratio_nxt = term ? ratio_dec : ratio_q;
    cnt_nxt   = term ? '0 : cnt_q + RATIO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RATIO_W'(RST_RATIO);
      cnt_q   <= '0;
    end else begin
      ratio_q <= ratio_nxt;
      cnt_q   <= cnt_nxt;
    end
  end

endmodule

// File: rtl/enc_div_shape.sv
module enc_div_shape #(
  parameter int RATIO_W = enc_div_pkg::RATIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_q,
  input  logic [RATIO_W-1:0] ratio_nxt,
  input  logic [RATIO_W-1:0] cnt_nxt,
  output logic               pos_q,
  output logic               neg_q,
  output logic               half_q
);

  logic [RATIO_W-1:0] rise_at;
  logic               pos_nxt;
  logic               rise_nxt;

  // High phase occupies the upper floor(R/2) counts of the period.
  assign rise_at  = ratio_nxt - (ratio_nxt >> 1);
  assign pos_nxt  = (cnt_nxt >= rise_at);
  assign rise_nxt = pos_nxt & ~pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      pos_q <= pos_nxt;
      if (rise_nxt) half_q <= ~half_q;
    end
  end

  // Odd ratios: hold the high phase half an input cycle longer.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_q & ratio_q[0];
  end

endmodule

// File: rtl/enc_ratio_div.sv
module enc_ratio_div
  import enc_div_pkg::*;
#(
  parameter int RATIO_W   = enc_div_pkg::RATIO_W,
  parameter int CODE_W    = enc_div_pkg::CODE_W,
  parameter int RST_RATIO = 2
) (
  input  logic              clk_vco,
  input  logic              rst_n,
  input  logic [1:0]        fam_sel,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              div_clk,
  output logic              half_clk
);

  logic [RATIO_W-1:0] w_ratio;
  logic [RATIO_W-1:0] w_cnt;
  logic [RATIO_W-1:0] w_ratio_nxt;
  logic [RATIO_W-1:0] w_cnt_nxt;
  logic               w_term;
  logic               w_pos;
  logic               w_neg;
  logic               w_half;

  enc_div_ctl #(
    .RATIO_W  (RATIO_W),
    .CODE_W   (CODE_W),
    .RST_RATIO(RST_RATIO)
  ) u_ctl (
    .clk      (clk_vco),
    .rst_n    (rst_n),
    .fam      (family_e'(fam_sel)),
    .code     (ratio_code),
    .ratio_q  (w_ratio),
    .cnt_q    (w_cnt),
    .ratio_nxt(w_ratio_nxt),
    .cnt_nxt  (w_cnt_nxt),
    .term     (w_term)
  );

  enc_div_shape #(
    .RATIO_W(RATIO_W)
  ) u_shape (
    .clk      (clk_vco),
    .rst_n    (rst_n),
    .ratio_q  (w_ratio),
    .ratio_nxt(w_ratio_nxt),
    .cnt_nxt  (w_cnt_nxt),
    .pos_q    (w_pos),
    .neg_q    (w_neg),
    .half_q   (w_half)
  );

  assign div_clk  = w_pos | w_neg;
  assign half_clk = w_half;

endmodule

// File: rtl/enc_div_chk.sv
module enc_div_chk #(
  parameter int RATIO_W = enc_div_pkg::RATIO_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               term,
  input logic [RATIO_W-1:0] cnt,
  input logic [RATIO_W-1:0] ratio,
  input logic               pos,
  input logic               neg,
  input logic               half
);

  // R7: ratio register moves only after the last count of a period
  p_ratio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(ratio));

  // R7: a finished period restarts the count at zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (cnt == '0));

  // R7: count never runs past the active ratio
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);

  // R1: active ratio stays within the legal decode range
  p_ratio_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio >= RATIO_W'(2)) && (ratio <= RATIO_W'(120)));

  // R6: companion output moves only with a rising divided phase
  p_half_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (half != $past(half)) |-> $rose(pos));

  // R5: no half-cycle stretch while an even ratio is active
  p_even_no_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio[0] |-> !neg);

endmodule

bind enc_ratio_div enc_div_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk  (clk_vco),
  .rst_n(rst_n),
  .term (w_term),
  .cnt  (w_cnt),
  .ratio(w_ratio),
  .pos  (w_pos),
  .neg  (w_neg),
  .half (w_half)
);

// File: tb/test_enc_ratio_div.sv
`timescale 1ns/1ps
module test_enc_ratio_div;

  logic       clk_vco = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] fam_sel = 2'b00;
  logic [3:0] ratio_code = 4'b0000;
  logic       div_clk;
  logic       half_clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic cur_d = 1'b0, prev_d = 1'b0, cur_h = 1'b0, prev_h = 1'b0;

  enc_ratio_div i_enc_ratio_div (
    .clk_vco   (clk_vco),
    .rst_n     (rst_n),
    .fam_sel   (fam_sel),
    .ratio_code(ratio_code),
    .div_clk   (div_clk),
    .half_clk  (half_clk)
  );

  always #2 clk_vco = ~clk_vco;

  // {family, code, expected ratio}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {2'b00, 4'b0000, 7'd2},   {2'b00, 4'b0001, 7'd3},
    {2'b00, 4'b0110, 7'd10},  {2'b00, 4'b1111, 7'd120},
    {2'b00, 4'b1011, 7'd60},  {2'b01, 4'b0000, 7'd4},
    {2'b01, 4'b1100, 7'd32},  {2'b01, 4'b0101, 7'd6},
    {2'b10, 4'b0011, 7'd7},   {2'b10, 4'b1111, 7'd56},
    {2'b10, 4'b1010, 7'd20},  {2'b11, 4'b0011, 7'd15}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One half-period step; samples land midway between clock edges.
  task automatic step();
    #2;
    prev_d = cur_d; prev_h = cur_h;
    cur_d  = div_clk; cur_h = half_clk;
  endtask

  task automatic wait_div_rise();
    int g = 0;
    do begin step(); g++; end while (!(cur_d && !prev_d) && g < 4000);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (cur_d == lvl && n < 4000) begin n++; step(); end
  endtask

  task automatic measure(input int r, input string req);
    int hi, per, hh, hp, g;
    wait_div_rise();
    chk(cur_h != prev_h, "R6 toggle at rise", int'(cur_h), int'(~prev_h));
    hi = 0; per = 0;
    do begin if (cur_d) hi++; per++; step(); end
      while (!(cur_d && !prev_d) && per < 4000);
    chk(per == 2*r, req, per, 2*r);
    chk(hi == r, "R5 duty", hi, r);
    g = 0;
    while (!(cur_h && !prev_h) && g < 4000) begin step(); g++; end
    hh = 0; hp = 0;
    do begin if (cur_h) hh++; hp++; step(); end
      while (!(cur_h && !prev_h) && hp < 4000);
    chk(hp == 4*r && hh == 2*r, "R6 half rate", hp, 4*r);
  endtask

  function automatic string fam_req(input logic [1:0] f);
    case (f)
      2'b00: return "R1 period";
      2'b01: return "R2 period";
      2'b10: return "R3 period";
      default: return "R4 period";
    endcase
  endfunction

  initial begin
    int w;
    #3;
    cur_d = div_clk; cur_h = half_clk;
    // R8: reset state
    chk(div_clk == 1'b0 && half_clk == 1'b0, "R8 reset low", int'(div_clk), 0);
    fam_sel = 2'b10; ratio_code = 4'b1111;
    step(); step(); step(); step();
    chk(div_clk == 1'b0, "R8 reset hold", int'(div_clk), 0);
    rst_n = 1'b1;
    // R8: first pulse at ratio 2, then the applied code (56)
    wait_div_rise();
    run_len(1'b1, w);
    chk(w == 2, "R8 first pulse", w, 2);
    measure(56, "R8 loaded ratio");

    // Main table of codes across all families
    for (int i = 0; i < NV; i++) begin
      fam_sel    = VEC[i][12:11];
      ratio_code = VEC[i][10:7];
      for (int k = 0; k < 300; k++) step();
      measure(int'(VEC[i][6:0]), fam_req(VEC[i][12:11]));
    end

    // R7: switch 120 -> 2 right after a rising edge
    fam_sel = 2'b00; ratio_code = 4'b1111;
    for (int k = 0; k < 300; k++) step();
    wait_div_rise();
    ratio_code = 4'b0000;
    run_len(1'b1, w);
    chk(w == 120, "R7 old high kept", w, 120);
    run_len(1'b0, w);
    chk(w == 2, "R7 new low", w, 2);
    run_len(1'b1, w);
    chk(w == 2, "R7 new high", w, 2);

    // R7: switch 15 -> 4 mid-period keeps the odd high width
    ratio_code = 4'b0011;
    for (int k = 0; k < 300; k++) step();
    wait_div_rise();
    fam_sel = 2'b01; ratio_code = 4'b0000;
    run_len(1'b1, w);
    chk(w == 15, "R7 odd high kept", w, 15);
    measure(4, "R7 after switch");

    // R8: asynchronous reset during operation forces outputs low
    #1; rst_n = 1'b0; #1;
    chk(div_clk == 1'b0 && half_clk == 1'b0, "R8 async reset", int'(div_clk | half_clk), 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule